// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Zero-Turnaround Bus

This block is a cycle-accurate, synthesizable model of a synchronous single-port SRAM. It has a common 36-bit data path, split into separate in, out and drive-enable ports, and four byte lanes of nine bits each. All synchronous inputs are captured on the rising clock edge. Read data flows straight out of the array during the cycle that follows the registered address, and no second output register is added.

Write data trails its address by one cycle. The captured data then waits in a coherency register until the next clock edge, when it is written into the array. Reads and writes can be mixed on consecutive cycles with no wait states. A read that lands on a word still held in the coherency register gets the pending bytes merged in.

A two-bit burst counter covers up to four beats from one supplied address, in linear or interleaved order. A clock enable can freeze the whole block on any edge.

Top module: `ft_burst_sram`

## Requirements
- R1: A read loaded at a clock edge (ld_adv=0, we_n=1, selected) drives d_out with the addressed word and raises d_oe during the cycle after that edge, with no further latency.
- R2: Reads and writes to different addresses can be issued on every consecutive clock edge in any mix, and each read returns the correct data with no idle cycle in between.
- R3: During a write, bw_n[i]=0 stores bits [9i+8:9i] of the write data and bw_n[i]=1 leaves those nine bits of the stored word unchanged.
- R4: A load edge selects the block only when ce1_n=0, ce2=1 and ce3_n=0. A load edge with any enable inactive deselects it, and d_oe is low in the cycle after that edge.
- R5: The data of a write is taken from d_in at the edge that follows its address edge. d_oe stays low through that data cycle, whatever oe_n is.
- R6: With ld_adv=1 after a selected load, each edge moves to the next beat of the burst. Only address bits [1:0] change, and after four beats they wrap back to the first.
- R7: The burst order is latched at the load edge. burst_lin=1 gives low bits = (start + beat) mod 4. burst_lin=0 gives low bits = start XOR beat.
- R8: oe_n acts without a clock. While oe_n=1, d_oe is low, and a read in progress drives again as soon as oe_n returns to 0.
- R9: While cen_n=1, a clock edge has no effect: no command is taken, no data is written, and d_out and d_oe keep their values.
- R10: A read issued on the edge right after a write to the same address returns the new data, merged lane by lane with the stored word according to that write's byte selects.
- R11: An advance edge keeps the read or write type of the burst whatever we_n is. An advance edge while deselected does nothing, and d_oe stays low.
- R12: While rst_n=0 and after its release, no access is active and d_oe is low until a selected read is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the control state |
| cen_n | input | 1 | Active-low clock enable; high freezes the block |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| ld_adv | input | 1 | 0 loads a new address and command, 1 advances the burst |
| we_n | input | 1 | Active-low write, sampled on load edges |
| bw_n | input | LANES | Active-low byte-lane write selects, one per 9-bit lane |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | AW | Word address; bits [1:0] seed the burst counter |
| oe_n | input | 1 | Asynchronous active-low output enable |
| d_in | input | LANES*LANE_W | Write data, valid one cycle after its address |
| d_out | output | LANES*LANE_W | Read data |
| d_oe | output | 1 | High when the block drives the data bus |

## Verification
The array read and the write forwarding path meet when a read follows, on the very next edge, a write to the same word. At that moment the write's data sits only in the coherency register, and the array still holds the old contents. The bench provokes this with full-word writes and with a partial write over a known word. It predicts each returned lane from the byte selects it applied: new bytes where a select was low, old bytes elsewhere. Stalls during a read burst are also interleaved, to confirm that a frozen edge neither commits pending data nor advances the beat.

// File: rtl/ft_burst_sram.sv
module ft_burst_sram #(
  parameter int AW     = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cen_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    ld_adv,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    burst_lin,
  input  logic [AW-1:0]           addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] d_in,
  output logic [LANES*LANE_W-1:0] d_out,
  output logic                    d_oe
);
  localparam int W     = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]     mem [DEPTH];

  logic             act_q, wr_q, lin_q;
  logic [AW-1:0]    base_q, adr_q;
  logic [1:0]       cnt_q;
  logic [LANES-1:0] bw_q;

  logic             wpend;
  logic [AW-1:0]    wadr;
  logic [W-1:0]     wdat;
  logic [LANES-1:0] wbw;

  logic             sel, fwd;
  logic [1:0]       ncnt, nlo;
  logic [W-1:0]     rd_word;

  assign sel  = !ce1_n && ce2 && !ce3_n;
  assign ncnt = cnt_q + 2'd1;
  assign nlo  = lin_q ? (base_q[1:0] + ncnt) : (base_q[1:0] ^ ncnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wpend <= 1'b0;
    end else if (!cen_n) begin
      wpend <= act_q && wr_q;
      if (!ld_adv)
        act_q <= sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!cen_n) begin
      wadr <= adr_q;
      wdat <= d_in;
      wbw  <= bw_q;
      bw_q <= bw_n;
      if (!ld_adv) begin
        wr_q   <= !we_n;
        lin_q  <= burst_lin;
        base_q <= addr;
        cnt_q  <= 2'd0;
        adr_q  <= addr;
      end else if (act_q) begin
        cnt_q <= ncnt;
        adr_q <= {base_q[AW-1:2], nlo};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !cen_n && wpend) begin
      for (int i = 0; i < LANES; i++)
        if (!wbw[i])
          mem[wadr][i*LANE_W +: LANE_W] <= wdat[i*LANE_W +: LANE_W];
    end
  end

  assign rd_word = mem[adr_q];
  assign fwd     = wpend && (wadr == adr_q);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign d_out[g*LANE_W +: LANE_W] = (fwd && !wbw[g]) ? wdat[g*LANE_W +: LANE_W]
                                                         : rd_word[g*LANE_W +: LANE_W];
  end

  assign d_oe = act_q && !wr_q && !oe_n;
endmodule

// File: rtl/ft_burst_sram_chk.sv
module ft_burst_sram_chk #(
  parameter int W = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cen_n,
  input logic         ce1_n,
  input logic         ce2,
  input logic         ce3_n,
  input logic         ld_adv,
  input logic         we_n,
  input logic         oe_n,
  input logic [W-1:0] d_out,
  input logic         d_oe
);
  AST_OE_GATES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !d_oe); // R8

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !ld_adv && !ce1_n && ce2 && !ce3_n && !we_n) |=> !d_oe); // R5

  AST_DESELECT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !ld_adv && (ce1_n || !ce2 || ce3_n)) |=> !d_oe); // R4

  AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n && d_oe) |=> $stable(d_out)); // R9

  AST_STALL_HOLDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n && d_oe && !oe_n) |=> (d_oe || oe_n)); // R9
endmodule

bind ft_burst_sram ft_burst_sram_chk #(.W(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .ld_adv(ld_adv), .we_n(we_n), .oe_n(oe_n), .d_out(d_out), .d_oe(d_oe)
);

// File: tb/ft_burst_sram_tb.sv
`timescale 1ns/1ps
module ft_burst_sram_tb;
  logic        clk = 1'b0;
  logic        rst_n, cen_n, ce1_n, ce2, ce3_n, ld_adv, we_n, burst_lin, oe_n;
  logic [3:0]  bw_n;
  logic [9:0]  addr;
  logic [35:0] d_in, d_out;
  logic        d_oe;
  int          total = 0;
  int          bad = 0;

  localparam logic [35:0] W1 = 36'h1_2345_6789;
  localparam logic [35:0] P  = 36'hA_AAAA_AAAA;
  localparam logic [35:0] Q  = 36'h5_5555_5555;
  localparam logic [35:0] M02 = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
  localparam logic [35:0] XV = 36'hC_0FFE_E123;
  localparam logic [35:0] YV = 36'h3_BEEF_0456;
  localparam logic [35:0] D0 = 36'h0_0000_0D00;
  localparam logic [35:0] D1 = 36'h1_1111_1D11;
  localparam logic [35:0] D2 = 36'h2_2222_2D22;
  localparam logic [35:0] D3 = 36'h3_3333_3D33;
  localparam logic [35:0] KV = 36'h7_7654_3210;
  localparam logic [35:0] JV = 36'h8_0000_0001;

  always #2.5 clk = ~clk;

  ft_burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .ld_adv(ld_adv), .we_n(we_n), .bw_n(bw_n), .burst_lin(burst_lin), .addr(addr),
    .oe_n(oe_n), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic l, input logic w, input logic [9:0] a,
                     input logic [3:0] b, input logic [35:0] d);
    ld_adv = l; we_n = w; addr = a; bw_n = b; d_in = d;
  endtask

  task automatic chk_q(input string tag, input logic [35:0] want);
    total++;
    if (d_oe !== 1'b1 || d_out !== want) begin
      bad++;
      $display("FAIL %s: d_oe=%b d_out=%h expected d_oe=1 d_out=%h", tag, d_oe, d_out, want);
    end
  endtask

  task automatic chk_z(input string tag);
    total++;
    if (d_oe !== 1'b0) begin
      bad++;
      $display("FAIL %s: d_oe=%b expected 0", tag, d_oe);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; cen_n = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; burst_lin = 1; oe_n = 0;
    put(0, 1, 10'h0, 4'hF, '0);
    tick(); tick(); tick();
    chk_z("R12 in reset");
    rst_n = 1;
    ce1_n = 1; put(0, 1, 10'h0, 4'hF, '0);
    tick();
    chk_z("R12 after release");
    ce1_n = 0;
    put(1, 0, 10'h0, 4'h0, W1);
    tick(); chk_z("R11 advance while deselected");
    put(1, 1, 10'h0, 4'hF, W1);
    tick(); chk_z("R11 advance while deselected, second edge");
  endtask

  task automatic t_forward();
    put(0, 0, 10'd5, 4'h0, '0);
    tick(); chk_z("R5 write data cycle not driven");
    put(0, 1, 10'd5, 4'hF, W1);
    tick(); chk_q("R10 read right after write", W1);
    ce1_n = 1; put(0, 1, 10'd0, 4'hF, '0);
    tick(); chk_z("R4 ce1_n inactive");
    ce1_n = 0; put(0, 1, 10'd5, 4'hF, '0);
    tick(); chk_q("R1 flow-through array read", W1);
  endtask

  task automatic t_bytes();
    put(0, 0, 10'd6, 4'h0, '0);
    tick(); chk_z("R5 first write");
    put(0, 0, 10'd6, 4'b1010, P);
    tick(); chk_z("R5 back-to-back write");
    put(0, 1, 10'd6, 4'hF, Q);
    tick(); chk_q("R3 R10 merged lanes", (Q & M02) | (P & ~M02));
    ce2 = 0; put(0, 1, 10'd0, 4'hF, '0);
    tick(); chk_z("R4 ce2 inactive");
    ce2 = 1; put(0, 1, 10'd6, 4'hF, '0);
    tick(); chk_q("R3 lanes in array", (Q & M02) | (P & ~M02));
  endtask

  task automatic t_b2b();
    put(0, 0, 10'd10, 4'h0, '0);
    tick(); chk_z("R2 write 10");
    put(0, 1, 10'd5, 4'hF, XV);
    tick(); chk_q("R2 read 5", W1);
    put(0, 0, 10'd11, 4'h0, '0);
    tick(); chk_z("R2 write 11");
    put(0, 1, 10'd10, 4'hF, YV);
    tick(); chk_q("R2 read 10", XV);
    put(0, 1, 10'd11, 4'hF, '0);
    tick(); chk_q("R2 read 11", YV);
  endtask

  task automatic t_burst();
    burst_lin = 1;
    put(0, 0, 10'h21, 4'h0, '0);
    tick(); chk_z("R6 burst write load");
    put(1, 1, 10'h0, 4'h0, D0);
    tick(); chk_z("R11 advance stays write");
    put(1, 1, 10'h0, 4'h0, D1);
    tick(); chk_z("R11 advance stays write 2");
    put(1, 1, 10'h0, 4'h0, D2);
    tick(); chk_z("R11 advance stays write 3");
    ce3_n = 1; put(0, 1, 10'h0, 4'hF, D3);
    tick(); chk_z("R4 ce3_n inactive");
    ce3_n = 0;
    burst_lin = 0; put(0, 1, 10'h22, 4'hF, '0);
    tick(); chk_q("R7 interleaved beat0", D1);
    burst_lin = 1; put(1, 0, 10'h0, 4'h0, '0);
    tick(); chk_q("R7 R11 interleaved beat1", D2);
    tick(); chk_q("R7 interleaved beat2", D3);
    tick(); chk_q("R7 interleaved beat3", D0);
    put(0, 1, 10'h23, 4'hF, '0);
    tick(); chk_q("R6 linear beat0", D2);
    put(1, 1, 10'h0, 4'hF, '0);
    tick(); chk_q("R6 linear beat1 wraps", D3);
    tick(); chk_q("R6 linear beat2", D0);
    tick(); chk_q("R6 linear beat3", D1);
    tick(); chk_q("R6 counter wraps to start", D2);
  endtask

  task automatic t_stall();
    put(0, 0, 10'h30, 4'h0, '0);
    tick(); chk_z("R5 write 0x30");
    put(0, 1, 10'h30, 4'hF, KV);
    tick(); chk_q("R10 read 0x30", KV);
    cen_n = 1; put(0, 0, 10'h30, 4'h0, JV);
    tick(); chk_q("R9 stalled edge ignored", KV);
    tick(); chk_q("R9 second stalled edge", KV);
    cen_n = 0; put(0, 1, 10'h30, 4'hF, JV);
    tick(); chk_q("R9 stalled write never stored", KV);
    put(0, 1, 10'h20, 4'hF, '0);
    tick(); chk_q("R9 burst start", D3);
    cen_n = 1; put(1, 1, 10'h0, 4'hF, '0);
    tick(); chk_q("R9 burst frozen", D3);
    cen_n = 0;
    tick(); chk_q("R9 burst resumes", D0);
  endtask

  task automatic t_oe();
    oe_n = 1; put(0, 1, 10'd5, 4'hF, '0);
    tick(); chk_z("R8 oe_n high");
    oe_n = 0; #1;
    chk_q("R8 async enable", W1);
    oe_n = 1; #1;
    chk_z("R8 async disable");
    oe_n = 0;
  endtask

  initial begin
    t_reset();
    t_forward();
    t_bytes();
    t_b2b();
    t_burst();
    t_stall();
    t_oe();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule